// File: doc/BRIEF.md
# Clock-Control Register Bank with Per-Field Write Guards

This block holds the two software-visible control bytes of a clock and reset generator: a PLL control byte and a clock-select byte. Software reaches them over a small byte-wide register bus with an address, a write strobe, write data and combinational read data. The analog PLL, its VCO, its loop filter and the interrupt and watchdog dividers live elsewhere. This block produces only the control levels that drive them.

Every field carries its own write rule, and status inputs decide it. The clock-monitor enable is frozen in self-clock mode. The PLL power bit is frozen while the PLL drives the system clock. The automatic-bandwidth bit is held at 1 while the PLL-wait input is high. The watchdog wait-stop bit may be written only once after reset in normal mode. A lock state machine tracks that rule. It has two states, OPEN and LOCKED, and one transition, OPEN to LOCKED, taken on the first write to the clock-select byte while the special-mode input is low. Only reset returns it to OPEN.

A second state machine follows the wait-mode input. It has two states, AWAKE and ASLEEP. The transition AWAKE to ASLEEP is taken on an edge where the wait input is high. The transition ASLEEP to AWAKE is taken on an edge where it is low. From these two states the block derives level stop signals and one-cycle divider-clear pulses for the real-time-interrupt and watchdog dividers.

Top module: `clkctl_regbank`

## Requirements
- R1: After reset the PLL control byte (address 0) reads 0xF1 and the clock-select byte (address 1) reads 0x00. The PLL control byte bits are 7 monitor enable, 6 PLL on, 5 auto bandwidth, 4 acquisition, 2 pre, 1 pce, 0 self-clock enable. The clock-select byte bits are 1 interrupt wait-stop and 0 watchdog wait-stop.
- R2: A write to address 0 leaves bit 7 unchanged while `self_clk_mode` is high.
- R3: A write to address 0 leaves bit 6 unchanged while `pll_selected` is high.
- R4: While `pll_wait` is high, bit 5 becomes 1 on the next edge and writes cannot clear it.
- R5: `pll_en` is high when bit 6 is 1 or `self_clk_mode` is high. A read of address 0 always returns the latched bit 6.
- R6: `hi_bw` equals `vco_far` when bit 5 is 1, and equals bit 4 when bit 5 is 0.
- R7: In normal mode (`special_mode` low), bit 0 of address 1 takes only the first write after reset and ignores later writes. With `special_mode` high every write is taken, and such writes do not lock the bit.
- R8: Bit 1 of address 1 is writable at any time. `rti_stop` is `wait_mode` AND bit 1, and `rti_clr` is high only in the first cycle of a wait period when bit 1 is 1. `cop_stop` and `cop_clr` behave the same way from bit 0.
- R9: `clkmon_en` is bit 7 and is forced low while `stop_mode` is high.
- R10: Bit 3 of address 0, bits 7..2 of address 1 and all other addresses read 0, and writes to them have no effect.
- R11: Bits 2, 1 and 0 of address 0 are writable at any time and drive `pre_en`, `pce_en` and `scm_en`. Every write takes effect on the rising edge that samples `bus_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| self_clk_mode | input | 1 | Self-clock mode status |
| pll_selected | input | 1 | PLL drives the system clock |
| pll_wait | input | 1 | PLL-wait control, holds auto bandwidth at 1 |
| special_mode | input | 1 | Special (test) operating mode |
| wait_mode | input | 1 | Device is in wait mode |
| stop_mode | input | 1 | Device is in stop mode |
| vco_far | input | 1 | Automatic request for high bandwidth |
| pll_en | output | 1 | PLL power enable |
| clkmon_en | output | 1 | Clock monitor enable |
| hi_bw | output | 1 | High-bandwidth filter select |
| pre_en | output | 1 | Pre field of PLL control byte |
| pce_en | output | 1 | Pce field of PLL control byte |
| scm_en | output | 1 | Self-clock enable field |
| rti_stop | output | 1 | Interrupt divider stop |
| rti_clr | output | 1 | Interrupt divider clear pulse |
| cop_stop | output | 1 | Watchdog divider stop |
| cop_clr | output | 1 | Watchdog divider clear pulse |

## Verification
The hardest case to reach is a rewrite of the watchdog wait-stop bit after it has locked. It needs a first write in normal mode, then later writes with the opposite value, with no reset in between. A variant interleaves special-mode writes before the first normal-mode write to show that they leave the lock open. The directed sequence builds exactly this ordering. A long random phase with rare resets then revisits it many times. Throughout, a behavioural model in the bench is compared with every output on every cycle.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
    localparam int BYTE_W = 8;

    localparam int PB_CME   = 7;
    localparam int PB_PLLON = 6;
    localparam int PB_AUTO  = 5;
    localparam int PB_ACQ   = 4;
    localparam int PB_PRE   = 2;
    localparam int PB_PCE   = 1;
    localparam int PB_SCME  = 0;

    localparam int SB_RTI = 1;
    localparam int SB_COP = 0;

    typedef enum logic {
        COP_OPEN   = 1'b0,
        COP_LOCKED = 1'b1
    } cop_lock_e;

    typedef enum logic {
        AWAKE  = 1'b0,
        ASLEEP = 1'b1
    } wait_st_e;
endpackage

// File: rtl/clkctl_pll_reg.sv
module clkctl_pll_reg
    import clkctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              self_clk_mode,
    input  logic              pll_selected,
    input  logic              pll_wait,
    input  logic              stop_mode,
    input  logic              vco_far,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              pll_en,
    output logic              clkmon_en,
    output logic              hi_bw,
    output logic              pre_en,
    output logic              pce_en,
    output logic              scm_en
);
    logic cme_q, pllon_q, auto_q, acq_q, pre_q, pce_q, scme_q;
    logic unused_rsvd;

    assign unused_rsvd = wdata[3];

    always_ff @(posedge clk) begin
        if (rst) begin
            cme_q   <= 1'b1;
            pllon_q <= 1'b1;
            auto_q  <= 1'b1;
            acq_q   <= 1'b1;
            pre_q   <= 1'b0;
            pce_q   <= 1'b0;
            scme_q  <= 1'b1;
        end else begin
            if (wr_en) begin
                if (!self_clk_mode) cme_q   <= wdata[PB_CME];
                if (!pll_selected)  pllon_q <= wdata[PB_PLLON];
                if (!pll_wait)      auto_q  <= wdata[PB_AUTO];
                acq_q  <= wdata[PB_ACQ];
                pre_q  <= wdata[PB_PRE];
                pce_q  <= wdata[PB_PCE];
                scme_q <= wdata[PB_SCME];
            end
            if (pll_wait) auto_q <= 1'b1;
        end
    end

    always_comb begin
        rd_byte           = '0;
        rd_byte[PB_CME]   = cme_q;
        rd_byte[PB_PLLON] = pllon_q;
        rd_byte[PB_AUTO]  = auto_q;
        rd_byte[PB_ACQ]   = acq_q;
        rd_byte[PB_PRE]   = pre_q;
        rd_byte[PB_PCE]   = pce_q;
        rd_byte[PB_SCME]  = scme_q;
        pll_en    = pllon_q | self_clk_mode;
        clkmon_en = cme_q & ~stop_mode;
        hi_bw     = auto_q ? vco_far : acq_q;
        pre_en    = pre_q;
        pce_en    = pce_q;
        scm_en    = scme_q;
    end

    a_r2_cme_frozen: assert property (@(posedge clk) disable iff (rst)
        (self_clk_mode && wr_en) |=> (cme_q == $past(cme_q)));

    a_r3_pllon_frozen: assert property (@(posedge clk) disable iff (rst)
        (pll_selected && wr_en) |=> (pllon_q == $past(pllon_q)));

    a_r4_auto_held: assert property (@(posedge clk) disable iff (rst)
        pll_wait |=> auto_q);

    a_r5_pllon_latched: assert property (@(posedge clk) disable iff (rst)
        (self_clk_mode && !pll_selected && wr_en) |=> (pllon_q == $past(wdata[PB_PLLON])));
endmodule

// File: rtl/clkctl_sel_reg.sv
module clkctl_sel_reg
    import clkctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_rti,
    input  logic              wr_cop,
    input  logic              special_mode,
    input  logic              wait_mode,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              rti_stop,
    output logic              rti_clr,
    output logic              cop_stop,
    output logic              cop_clr
);
    cop_lock_e lock_q, lock_d;
    wait_st_e  wst_q, wst_d;
    logic      rtiwai_q, copwai_q;
    logic      cop_wr_ok;

    always_comb begin
        lock_d = lock_q;
        unique case (lock_q)
            COP_OPEN:   if (wr_en && !special_mode) lock_d = COP_LOCKED;
            COP_LOCKED: lock_d = COP_LOCKED;
        endcase
        wst_d = wst_q;
        unique case (wst_q)
            AWAKE:  if (wait_mode)  wst_d = ASLEEP;
            ASLEEP: if (!wait_mode) wst_d = AWAKE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= COP_OPEN;
            wst_q  <= AWAKE;
        end else begin
            lock_q <= lock_d;
            wst_q  <= wst_d;
        end
    end

    assign cop_wr_ok = special_mode || (lock_q == COP_OPEN);

    always_ff @(posedge clk) begin
        if (rst) begin
            rtiwai_q <= 1'b0;
            copwai_q <= 1'b0;
        end else if (wr_en) begin
            rtiwai_q <= wr_rti;
            if (cop_wr_ok) copwai_q <= wr_cop;
        end
    end

    always_comb begin
        rd_byte         = '0;
        rd_byte[SB_RTI] = rtiwai_q;
        rd_byte[SB_COP] = copwai_q;
        rti_stop = wait_mode & rtiwai_q;
        cop_stop = wait_mode & copwai_q;
        rti_clr  = wait_mode & (wst_q == AWAKE) & rtiwai_q;
        cop_clr  = wait_mode & (wst_q == AWAKE) & copwai_q;
    end

    a_r7_cop_locked: assert property (@(posedge clk) disable iff (rst)
        (lock_q == COP_LOCKED && !special_mode && wr_en) |=> $stable(copwai_q));

    a_r7_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        (lock_q == COP_LOCKED) |=> (lock_q == COP_LOCKED));

    a_r8_rti_pulse: assert property (@(posedge clk) disable iff (rst)
        rti_clr |=> !rti_clr);

    a_r8_cop_pulse: assert property (@(posedge clk) disable iff (rst)
        cop_clr |=> !cop_clr);
endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
    import clkctl_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int PLL_ADDR = 0,
    parameter int SEL_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              self_clk_mode,
    input  logic              pll_selected,
    input  logic              pll_wait,
    input  logic              special_mode,
    input  logic              wait_mode,
    input  logic              stop_mode,
    input  logic              vco_far,
    output logic              pll_en,
    output logic              clkmon_en,
    output logic              hi_bw,
    output logic              pre_en,
    output logic              pce_en,
    output logic              scm_en,
    output logic              rti_stop,
    output logic              rti_clr,
    output logic              cop_stop,
    output logic              cop_clr
);
    localparam logic [ADDR_W-1:0] A_PLL = ADDR_W'(PLL_ADDR);
    localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(SEL_ADDR);

    logic [BYTE_W-1:0] pll_byte, sel_byte;
    logic              pll_wr, sel_wr;

    assign pll_wr = bus_we && (bus_addr == A_PLL);
    assign sel_wr = bus_we && (bus_addr == A_SEL);

    clkctl_pll_reg u_pll (
        .clk(clk), .rst(rst), .wr_en(pll_wr), .wdata(bus_wdata),
        .self_clk_mode(self_clk_mode), .pll_selected(pll_selected),
        .pll_wait(pll_wait), .stop_mode(stop_mode), .vco_far(vco_far),
        .rd_byte(pll_byte), .pll_en(pll_en), .clkmon_en(clkmon_en),
        .hi_bw(hi_bw), .pre_en(pre_en), .pce_en(pce_en), .scm_en(scm_en)
    );

    clkctl_sel_reg u_sel (
        .clk(clk), .rst(rst), .wr_en(sel_wr),
        .wr_rti(bus_wdata[SB_RTI]), .wr_cop(bus_wdata[SB_COP]),
        .special_mode(special_mode), .wait_mode(wait_mode),
        .rd_byte(sel_byte), .rti_stop(rti_stop), .rti_clr(rti_clr),
        .cop_stop(cop_stop), .cop_clr(cop_clr)
    );

    always_comb begin
        if (bus_addr == A_PLL)      bus_rdata = pll_byte;
        else if (bus_addr == A_SEL) bus_rdata = sel_byte;
        else                        bus_rdata = '0;
    end

    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr != A_PLL && bus_addr != A_SEL) |-> (bus_rdata == 8'h00));
endmodule

// File: tb/tb_clkctl_regbank.sv
module tb_clkctl_regbank;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic scm_in = 0, psel = 0, pwait = 0, spec = 0, waitm = 0, stopm = 0, vfar = 0;
    logic pll_en, clkmon_en, hi_bw, pre_en, pce_en, scm_en;
    logic rti_stop, rti_clr, cop_stop, cop_clr;

    int checks = 0, errors = 0, cycles = 0;
    logic [7:0] m_pll = 8'hF1, m_sel = 8'h00;
    bit m_lock = 0, m_prevwait = 0;

    always #2.5 clk = ~clk;

    clkctl_regbank dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .self_clk_mode(scm_in), .pll_selected(psel), .pll_wait(pwait),
        .special_mode(spec), .wait_mode(waitm), .stop_mode(stopm), .vco_far(vfar),
        .pll_en(pll_en), .clkmon_en(clkmon_en), .hi_bw(hi_bw),
        .pre_en(pre_en), .pce_en(pce_en), .scm_en(scm_en),
        .rti_stop(rti_stop), .rti_clr(rti_clr), .cop_stop(cop_stop), .cop_clr(cop_clr)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Reference model: behaviour from the requirements
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_pll = 8'hF1; m_sel = 8'h00; m_lock = 0; m_prevwait = 0;
        end else begin
            if (bus_we && bus_addr == 2'd0) begin
                if (!scm_in) m_pll[7] = bus_wdata[7];
                if (!psel)   m_pll[6] = bus_wdata[6];
                if (!pwait)  m_pll[5] = bus_wdata[5];
                m_pll[4] = bus_wdata[4];
                m_pll[2:0] = bus_wdata[2:0];
            end
            if (pwait) m_pll[5] = 1'b1;
            if (bus_we && bus_addr == 2'd1) begin
                m_sel[1] = bus_wdata[1];
                if (spec || !m_lock) m_sel[0] = bus_wdata[0];
                if (!spec) m_lock = 1;
            end
            m_prevwait = waitm;
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            logic [7:0] exp_rd;
            exp_rd = (bus_addr == 2'd0) ? m_pll : (bus_addr == 2'd1) ? m_sel : 8'h00;
            chk("R10 rdata", bus_rdata, exp_rd);
            chk("R5 pll_en", {7'd0, pll_en}, {7'd0, m_pll[6] | scm_in});
            chk("R9 clkmon_en", {7'd0, clkmon_en}, {7'd0, m_pll[7] & ~stopm});
            chk("R6 hi_bw", {7'd0, hi_bw}, {7'd0, m_pll[5] ? vfar : m_pll[4]});
            chk("R11 aux", {5'd0, pre_en, pce_en, scm_en}, {5'd0, m_pll[2:0]});
            chk("R8 stops", {6'd0, rti_stop, cop_stop},
                {6'd0, waitm & m_sel[1], waitm & m_sel[0]});
            chk("R8 clears", {6'd0, rti_clr, cop_clr},
                {6'd0, waitm & ~m_prevwait & m_sel[1], waitm & ~m_prevwait & m_sel[0]});
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        bus_addr = a; bus_we = 1; bus_wdata = d; step(); bus_we = 0;
    endtask

    task automatic rd_chk(string tag, logic [1:0] a, logic [7:0] exp);
        bus_addr = a; #1; chk(tag, bus_rdata, exp);
    endtask

    task automatic do_reset();
        rst = 1; step(); step(); rst = 0; step();
    endtask

    initial begin
        forever begin
            @(posedge clk);
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        do_reset();
        rd_chk("R1 pll reset", 2'd0, 8'hF1);
        rd_chk("R1 sel reset", 2'd1, 8'h00);
        // R2/R3 guards active
        scm_in = 1; psel = 1;
        wr(2'd0, 8'h08);
        rd_chk("R2 R3 guarded write", 2'd0, 8'hC0);
        scm_in = 0; psel = 0;
        wr(2'd0, 8'h00);
        rd_chk("R2 R3 open write", 2'd0, 8'h00);
        // R5 readback differs in self-clock mode
        scm_in = 1; step();
        rd_chk("R5 latched pllon", 2'd0, 8'h00);
        chk("R5 pll_en forced", {7'd0, pll_en}, 8'h01);
        scm_in = 0;
        // R4
        pwait = 1; step();
        rd_chk("R4 auto forced", 2'd0, 8'h20);
        wr(2'd0, 8'h00);
        rd_chk("R4 auto held", 2'd0, 8'h20);
        pwait = 0;
        // R7 special-mode writes do not lock
        spec = 1;
        wr(2'd1, 8'h01); wr(2'd1, 8'h00);
        rd_chk("R7 special rewrite", 2'd1, 8'h00);
        spec = 0;
        wr(2'd1, 8'hFF);
        rd_chk("R7 R10 first normal write", 2'd1, 8'h03);
        wr(2'd1, 8'h00);
        rd_chk("R7 locked cop", 2'd1, 8'h01);
        wr(2'd1, 8'h02);
        rd_chk("R8 rti anytime", 2'd1, 8'h03);
        // R8 wait entry
        waitm = 1; #1;
        chk("R8 clr on entry", {6'd0, rti_clr, cop_clr}, 8'h03);
        step();
        chk("R8 clr one cycle", {6'd0, rti_clr, cop_clr}, 8'h00);
        chk("R8 stop level", {6'd0, rti_stop, cop_stop}, 8'h03);
        waitm = 0; step();
        // R9
        stopm = 1; #1;
        chk("R9 stop forces off", {7'd0, clkmon_en}, 8'h00);
        stopm = 0;
        // R10 unmapped address
        wr(2'd2, 8'hFF);
        rd_chk("R10 unmapped", 2'd2, 8'h00);
        // Random phase, compared every cycle by the model
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 299) == 0) do_reset();
            bus_addr  = 2'($urandom_range(0, 3));
            bus_we    = ($urandom_range(0, 2) == 0);
            bus_wdata = 8'($urandom);
            scm_in = ($urandom_range(0, 3) == 0);
            psel   = ($urandom_range(0, 3) == 0);
            pwait  = ($urandom_range(0, 5) == 0);
            spec   = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 4) == 0) waitm = ~waitm;
            stopm  = ($urandom_range(0, 5) == 0);
            vfar   = 1'($urandom);
            step();
        end
        bus_we = 0;
        step();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule